// File: doc/BRIEF.md
# Timestamped Shared Bus Scheduler

This block arbitrates a single shared bus for a discrete-event simulation engine built from many nodes. Every node offers a ready flag and the timestamp of the packet at the head of its queue. Each clock, the scheduler moves at most one packet across the bus. It keeps a global simulation time. That time stays put while eligible packets remain, and it steps forward by one when none remain.

A packet is eligible when its node is ready and its timestamp is no later than the current time plus a lookahead `READY_DELTA`. Packets stamped behind the current time count as eligible. The time step depends on one condition only: whether any eligible packet exists. The block never tests for a second ready packet. As a result, one idle cycle follows the last packet of a timestep. The search for an eligible packet runs as two half-length chains, one over even node indices and one over odd ones. Their results are merged so that the lowest index wins.

The dequeue grant, the delivered source index, the delivered timestamp and the valid flag are all decoded combinationally from the same selection, so they appear in the same cycle. The node then presents its next head packet on the following cycle.

Top module: `tsbus_sched`

## Requirements
- R1: At most one bit of `node_deq` is high in any cycle.
- R2: With `READY_DELTA` = 1 (the default), a ready node is eligible when its timestamp minus `cur_time` is at most 1. The difference is taken as a two's-complement value of `TS_W` bits, so late timestamps with a negative difference are eligible and a difference of +2 or more is not.
- R3: In a cycle with `bus_valid` high, `cur_time` holds its value across the next clock edge.
- R4: In an active cycle with `bus_valid` low, `cur_time` increases by exactly one at the next clock edge.
- R5: `bus_valid` is high exactly when some node is eligible. When it is high, `node_deq` is one-hot at bit `bus_src`, and `bus_ts` equals that node's timestamp, all in the same cycle.
- R6: Among eligible nodes the lowest index is selected, whether the winner has an even or an odd index.
- R7: A node whose ready flag is low is never selected, even if its timestamp equals `cur_time`.
- R8: The time comparison stays correct across wraparound. At `cur_time` = 0xFFFF, a timestamp of 0x0000 is eligible and 0x0001 is not, and `cur_time` steps from 0xFFFF to 0x0000.
- R9: While reset is asserted, and until two clock edges after its release, `cur_time` is 0 and `bus_valid` and `node_deq` are low, whatever the nodes present.
- R10: After the last eligible packet of a timestep is sent, one cycle follows with `bus_valid` low and `cur_time` unchanged. Only after that cycle does the time advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_ready | input | N_NODES | Per-node flag: the head packet exists |
| node_ts | input | N_NODES*TS_W | Per-node head timestamp; node i occupies bits [i*TS_W +: TS_W] |
| node_deq | output | N_NODES | One-hot dequeue grant to the selected node |
| bus_valid | output | 1 | A packet is on the bus this cycle |
| bus_src | output | IDX_W | Index of the node whose packet is on the bus |
| bus_ts | output | TS_W | Timestamp of the packet on the bus |
| cur_time | output | TS_W | Current simulation timestep |

## Verification
The hardest condition to reach from the ports is the time counter wrapping while packets sit on both sides of the wrap point. The counter moves only on idle cycles. The bench therefore holds every node idle for about 65 thousand cycles until `cur_time` reads 0xFFFF. It then presents one packet stamped 0x0000 and one stamped 0x0001, and checks the selection, the hold, and the step to 0x0000. The bubble cycle after a burst is reached by modelling the node queues in the bench: each granted node's ready flag is cleared after the edge, so the bench can watch the idle cycle that follows the burst.

// File: rtl/tsbus_pkg.sv
package tsbus_pkg;
  // Action applied to the simulation time at the next edge
  typedef enum logic {
    TACT_HOLD = 1'b0,
    TACT_STEP = 1'b1
  } tact_e;
endpackage

// File: rtl/tsbus_rstsync.sv
module tsbus_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic ff1_q, ff2_q;
  logic ff1_d, ff2_d;

  always_comb begin
    ff1_d = 1'b1;
    ff2_d = ff1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= ff1_d;
      ff2_q <= ff2_d;
    end
  end

  assign rst_q = ff2_q;
endmodule

// File: rtl/tsbus_elig.sv
module tsbus_elig #(
  parameter int N_NODES     = 8,
  parameter int TS_W        = 16,
  parameter int READY_DELTA = 1
) (
  input  logic                    en,
  input  logic [N_NODES-1:0]      ready,
  input  logic [N_NODES*TS_W-1:0] ts,
  input  logic [TS_W-1:0]         now,
  output logic [N_NODES-1:0]      elig
);
  localparam logic signed [TS_W-1:0] DLT = TS_W'(READY_DELTA);

  for (genvar i = 0; i < N_NODES; i++) begin : g_node
    logic [TS_W-1:0] diff;
    logic            in_win;
    always_comb begin
      diff    = ts[i*TS_W +: TS_W] - now;
      in_win  = ($signed(diff) <= DLT);
      elig[i] = en & ready[i] & in_win;
    end
  end
endmodule

// File: rtl/tsbus_chain.sv
module tsbus_chain #(
  parameter int LEN   = 4,
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN-1:0]   req,
  output logic             found,
  output logic [POS_W-1:0] pos
);
  logic [LEN-1:0] gnt;
  logic [LEN:0]   taken;

  // ripple priority chain: earliest request wins
  always_comb begin
    taken[0] = 1'b0;
    for (int k = 0; k < LEN; k++) begin
      gnt[k]     = req[k] & ~taken[k];
      taken[k+1] = taken[k] | req[k];
    end
    found = taken[LEN];
  end

  always_comb begin
    pos = '0;
    for (int k = 0; k < LEN; k++) begin
      if (gnt[k]) pos = pos | POS_W'(k);
    end
  end

  AST_CHAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1
  AST_CHAIN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0)); // R6
endmodule

// File: rtl/tsbus_sched.sv
module tsbus_sched
  import tsbus_pkg::*;
#(
  parameter int N_NODES     = 8,
  parameter int TS_W        = 16,
  parameter int READY_DELTA = 1,
  localparam int IDX_W      = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int LEN_E      = (N_NODES + 1) / 2,
  localparam int LEN_O      = N_NODES / 2,
  localparam int POS_E_W    = (LEN_E > 1) ? $clog2(LEN_E) : 1,
  localparam int POS_O_W    = (LEN_O > 1) ? $clog2(LEN_O) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_NODES-1:0]      node_ready,
  input  logic [N_NODES*TS_W-1:0] node_ts,
  output logic [N_NODES-1:0]      node_deq,
  output logic                    bus_valid,
  output logic [IDX_W-1:0]        bus_src,
  output logic [TS_W-1:0]         bus_ts,
  output logic [TS_W-1:0]         cur_time
);
  localparam logic signed [TS_W-1:0] DLT = TS_W'(READY_DELTA);

  logic               rst_q;
  logic [N_NODES-1:0] elig;
  logic [LEN_E-1:0]   elig_e;
  logic [LEN_O-1:0]   elig_o;
  logic               found_e, found_o;
  logic [POS_E_W-1:0] pos_e;
  logic [POS_O_W-1:0] pos_o;
  logic [IDX_W-1:0]   idx_e, idx_o, sel;
  logic               any;
  tact_e              tact;
  logic [TS_W-1:0]    time_q, time_d;
  logic               time_en;

  tsbus_rstsync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  tsbus_elig #(
    .N_NODES     (N_NODES),
    .TS_W        (TS_W),
    .READY_DELTA (READY_DELTA)
  ) u_elig (
    .en    (rst_q),
    .ready (node_ready),
    .ts    (node_ts),
    .now   (time_q),
    .elig  (elig)
  );

  // split into interleaved halves
  for (genvar k = 0; k < LEN_E; k++) begin : g_even
    assign elig_e[k] = elig[2*k];
  end
  for (genvar k = 0; k < LEN_O; k++) begin : g_odd
    assign elig_o[k] = elig[2*k+1];
  end

  tsbus_chain #(.LEN(LEN_E), .POS_W(POS_E_W)) u_chain_e (
    .clk   (clk),
    .rst_n (rst_q),
    .req   (elig_e),
    .found (found_e),
    .pos   (pos_e)
  );

  tsbus_chain #(.LEN(LEN_O), .POS_W(POS_O_W)) u_chain_o (
    .clk   (clk),
    .rst_n (rst_q),
    .req   (elig_o),
    .found (found_o),
    .pos   (pos_o)
  );

  // merge: lowest overall index wins
  always_comb begin
    idx_e = IDX_W'({pos_e, 1'b0});
    idx_o = IDX_W'({pos_o, 1'b1});
    any   = found_e | found_o;
    if (found_e && (!found_o || (idx_e < idx_o))) sel = idx_e;
    else                                          sel = idx_o;
  end

  // bus outputs and grant
  always_comb begin
    bus_valid = any;
    bus_src   = any ? sel : '0;
    node_deq  = '0;
    bus_ts    = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (any && (sel == IDX_W'(i))) begin
        node_deq[i] = 1'b1;
        bus_ts      = node_ts[i*TS_W +: TS_W];
      end
    end
  end

  // time next-state
  always_comb begin
    tact    = any ? TACT_HOLD : TACT_STEP;
    time_en = rst_q & (tact == TACT_STEP);
    time_d  = time_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_en) time_q <= time_d;
  end

  assign cur_time = time_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(node_deq)); // R1
  AST_TS_WINDOW: assert property (@(posedge clk) disable iff (!rst_q)
    bus_valid |-> ($signed(bus_ts - cur_time) <= DLT)); // R2
  AST_HOLD_TIME: assert property (@(posedge clk) disable iff (!rst_q)
    bus_valid |=> $stable(cur_time)); // R3
  AST_STEP_TIME: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_valid |=> (cur_time == $past(cur_time) + TS_W'(1))); // R4
  AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_q)
    bus_valid |-> (node_deq[bus_src] && node_ready[bus_src])); // R5
  AST_IDLE_NOGRANT: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_valid |-> (node_deq == '0)); // R5
endmodule

// File: tb/sim_tsbus_sched.sv
`timescale 1ns/1ps
module sim_tsbus_sched;
  localparam int N  = 8;
  localparam int TW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    node_ready;
  logic [N*TW-1:0] node_ts;
  logic [N-1:0]    node_deq;
  logic            bus_valid;
  logic [2:0]      bus_src;
  logic [TW-1:0]   bus_ts;
  logic [TW-1:0]   cur_time;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tsbus_sched #(.N_NODES(N), .TS_W(TW), .READY_DELTA(1)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_ready (node_ready),
    .node_ts    (node_ts),
    .node_deq   (node_deq),
    .bus_valid  (bus_valid),
    .bus_src    (bus_src),
    .bus_ts     (bus_ts),
    .cur_time   (cur_time)
  );

  // vector: [43:36] ready, [35:4] 4-bit signed offset per node, [3] valid, [2:0] src
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {8'h00, 32'h0000_0000, 1'b0, 3'd0},  // R4 nothing ready
    {8'hFF, 32'h0000_0000, 1'b1, 3'd0},  // R6 all at T
    {8'hA0, 32'h0000_0000, 1'b1, 3'd5},  // R6 odd winner
    {8'hFF, 32'h5555_5132, 1'b1, 3'd2},  // R2 only node2 at +1
    {8'hFF, 32'h2222_2222, 1'b0, 3'd0},  // R2 all at +2
    {8'h08, 32'h0000_E000, 1'b1, 3'd3},  // R2 late packet
    {8'h80, 32'h1000_0000, 1'b1, 3'd7},  // R2 top node at +1
    {8'h06, 32'h0000_0000, 1'b1, 3'd1},  // R6 odd below even
    {8'h0C, 32'h0000_0000, 1'b1, 3'd2},  // R6 even below odd
    {8'h80, 32'h0000_0000, 1'b1, 3'd7}   // R7 not-ready nodes at T ignored
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_ts(input int i, input logic [TW-1:0] v);
    node_ts[i*TW +: TW] = v;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [TW-1:0] t0;
    logic [7:0]    exp_deq;
    rst_n      = 1'b0;
    node_ready = '1;
    node_ts    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(cur_time == 0, "R9", "cur_time in reset", cur_time, 0);
    chk(!bus_valid && node_deq == 0, "R9", "grant in reset", node_deq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid && cur_time == 0, "R9", "grant before sync", {bus_valid, cur_time}, 0);
    node_ready = '0;
    repeat (2) @(negedge clk);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [43:0] e;
      e  = VEC[v];
      t0 = cur_time;
      node_ready = e[43:36];
      for (int i = 0; i < N; i++) begin
        logic [3:0] off;
        off = e[4+4*i +: 4];
        set_ts(i, t0 + {{(TW-4){off[3]}}, off});
      end
      #1;
      exp_deq = e[3] ? (8'd1 << e[2:0]) : 8'd0;
      chk(bus_valid == e[3], "R2", "valid", bus_valid, e[3]);
      chk(node_deq == exp_deq, "R5", "deq", node_deq, exp_deq);
      if (e[3]) begin
        chk(bus_src == e[2:0], "R6", "src", bus_src, e[2:0]);
        chk(bus_ts == node_ts[e[2:0]*TW +: TW], "R5", "bus_ts",
            bus_ts, node_ts[e[2:0]*TW +: TW]);
      end
      @(posedge clk);
      #1;
      chk(cur_time == t0 + (e[3] ? 16'd0 : 16'd1), e[3] ? "R3" : "R4",
          "time step", cur_time, t0 + (e[3] ? 16'd0 : 16'd1));
      node_ready = '0;
      @(negedge clk);
    end

    // R10 burst then bubble; bench models queue pops
    t0 = cur_time;
    node_ready = 8'h29;
    for (int i = 0; i < N; i++) set_ts(i, t0);
    for (int k = 0; k < 3; k++) begin
      logic [2:0] es;
      es = (k == 0) ? 3'd0 : (k == 1) ? 3'd3 : 3'd5;
      #1;
      chk(bus_valid && bus_src == es, "R6", "burst src", bus_src, es);
      chk(node_deq == (8'd1 << es), "R1", "burst deq", node_deq, 8'd1 << es);
      chk(cur_time == t0, "R3", "burst hold", cur_time, t0);
      @(posedge clk);
      #1;
      node_ready[es] = 1'b0;
      @(negedge clk);
    end
    #1;
    chk(!bus_valid, "R10", "bubble valid", bus_valid, 0);
    chk(cur_time == t0, "R10", "bubble time", cur_time, t0);
    @(posedge clk);
    #1;
    chk(cur_time == t0 + 16'd1, "R10", "after bubble", cur_time, t0 + 16'd1);

    // R8 wraparound
    while (cur_time != 16'hFFFF) @(negedge clk);
    node_ready = 8'h14;
    set_ts(4, 16'h0000);
    set_ts(2, 16'h0001);
    #1;
    chk(bus_valid && bus_src == 3'd4, "R8", "wrap select", bus_src, 4);
    @(posedge clk);
    #1;
    chk(cur_time == 16'hFFFF, "R8", "wrap hold", cur_time, 16'hFFFF);
    node_ready[4] = 1'b0;
    @(negedge clk);
    #1;
    chk(!bus_valid, "R8", "wrap +2 blocked", bus_valid, 0);
    @(posedge clk);
    #1;
    chk(cur_time == 16'h0000, "R8", "wrap step", cur_time, 0);
    @(negedge clk);
    #1;
    chk(bus_valid && bus_src == 3'd2, "R8", "post-wrap select", bus_src, 2);
    node_ready = '0;
    @(negedge clk);

    finish_run();
  end
endmodule